// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits beside the main command arbiter of an SDRAM controller and keeps a four-bank device refreshed. An interval timer expires once per average refresh interval, which is the refresh window divided by the number of refresh commands the array needs in that window. On each expiry the block asks the arbiter for the command bus. Once granted, it closes any open rows with PRECHARGE ALL and waits the row precharge time. It then issues AUTO REFRESH and holds the bus with NOPs for the refresh cycle time.

The same timer doubles as a deadline watchdog. If a second expiry arrives while the first request is still waiting for a grant, the deadline counts as missed, and the next sequence issues two refreshes back to back instead of one. A separate request/acknowledge pair moves the device into self refresh: the banks are closed, SELF REFRESH is issued with CKE low, and CKE stays low until the request is withdrawn. On exit CKE rises and only NOPs follow for the refresh cycle time before the device is declared idle.

All timings are parameters in picoseconds or nanoseconds and become clock counts inside the block. The command output is a two-bit code that the arbiter forwards to the command pins while it grants the bus.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and right after a synchronous reset, `cmd` is NOP (code 0), `cke` is 1, `arb_req` is 0 and `sr_ack` is 0, and the interval timer is reloaded.
- R2: The interval is REFI = floor(REF_WINDOW_NS*1000 / (REF_COUNT*CLK_PS)) cycles. `arb_req` first rises REFI+1 cycles after the last reset edge, and the timer expires again every REFI cycles from then on.
- R3: `cmd` is NOP whenever `arb_req` is 0 and on the first cycle of every request. A sequence starts only on the cycle after `arb_gnt` is seen high together with `arb_req`.
- R4: If `banks_idle` is 0 when the grant is taken, PRECHARGE ALL (code 1) is issued first, and the next command follows exactly TRP cycles later. If `banks_idle` is 1, no precharge is issued.
- R5: AUTO REFRESH (code 2) is followed by NOPs, and the next command or the release of `arb_req` comes RFC cycles after it. A plain granted refresh with idle banks keeps `arb_req` high for RFC+1 cycles.
- R6: If the interval expires again while a refresh is still pending, the next granted sequence issues two AUTO REFRESH commands spaced RFC cycles apart.
- R7: TRP = ceil(TRP_PS/CLK_PS) and RFC = ceil(TRFC_PS/CLK_PS); each is at least 2.
- R8: A self-refresh request (`sr_req`) from idle obtains a grant, closes the banks as in R4, then issues SELF REFRESH (code 3). `cke` is 0 and `sr_ack` is 1 in that same cycle, and `cke` stays 0 while `sr_req` stays 1.
- R9: When `sr_req` falls in self refresh, `cke` rises on the next cycle. Only NOPs follow for RFC cycles, after which `sr_ack` and `arb_req` fall together.
- R10: When a refresh is pending and `sr_req` is also high in idle, the refresh sequence runs first.
- R11: While `sr_ack` is 1 the interval timer is held and no AUTO REFRESH is issued. After exit, `arb_req` next rises REFI+1 cycles after the first cycle with `sr_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_gnt | input | 1 | Bus grant from the command arbiter |
| banks_idle | input | 1 | All banks are precharged, as reported by the arbiter |
| sr_req | input | 1 | Request to enter (1) or leave (0) self refresh |
| arb_req | output | 1 | Bus request to the arbiter, held for the whole sequence |
| cke | output | 1 | Clock enable for the device |
| cmd | output | 2 | Command code: 0 NOP, 1 PRECHARGE ALL, 2 AUTO REFRESH, 3 SELF REFRESH |
| sr_ack | output | 1 | High from self-refresh entry until the post-exit NOP wait ends |

## Verification
The properties assume that the arbiter asserts `arb_gnt` only while `arb_req` is high and keeps it high until `arb_req` drops. They also assume that `banks_idle` is valid in the cycle the grant is taken. The bench drives the grant from a per-phase delay counter that starts when `arb_req` rises and clears when it falls, so the grant never leads or outlives the request. `sr_req` is raised only while the sequencer is idle or busy with a refresh, and it is dropped only after `sr_ack` has been observed high.

// File: rtl/sdram_rf_pkg.sv
`timescale 1ns/1ps
package sdram_rf_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_PREA  = 2'd1,
        CMD_AREF  = 2'd2,
        CMD_SREF  = 2'd3
    } rf_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_RFC,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT
    } rf_state_e;

    typedef struct packed {
        rf_state_e st;
        logic      goal_sr;
        logic      pend;
        logic      missed;
        logic      extra;
    } rf_fsm_regs_t;

endpackage

// File: rtl/rf_interval_timer.sv
`timescale 1ns/1ps
module rf_interval_timer #(
    parameter int unsigned PERIOD = 1953
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int unsigned CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = !hold && (cnt_q == '0);
        if (hold || tick) begin
            cnt_d = RELOAD;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rf_delay_cnt.sv
`timescale 1ns/1ps
module rf_delay_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        zero = (cnt_q == '0);
        if (load) begin
            cnt_d = load_val;
        end else if (!zero) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rf_seq_fsm.sv
`timescale 1ns/1ps
module rf_seq_fsm
    import sdram_rf_pkg::*;
#(
    parameter int unsigned DLY_W   = 4,
    parameter int unsigned TRP_CYC = 3,
    parameter int unsigned RFC_CYC = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             dly_zero,
    input  logic             arb_gnt,
    input  logic             banks_idle,
    input  logic             sr_req,
    output logic             dly_load,
    output logic [DLY_W-1:0] dly_val,
    output logic             hold,
    output logic             arb_req,
    output logic             cke,
    output logic [1:0]       cmd,
    output logic             sr_ack
);
    // Wait loads: a command state lasts one cycle, so the wait that follows
    // it is one cycle shorter than the spacing; the exit wait counts itself.
    localparam logic [DLY_W-1:0] LD_TRP  = DLY_W'(TRP_CYC - 2);
    localparam logic [DLY_W-1:0] LD_RFC  = DLY_W'(RFC_CYC - 2);
    localparam logic [DLY_W-1:0] LD_EXIT = DLY_W'(RFC_CYC - 1);

    rf_fsm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        dly_load = 1'b0;
        dly_val  = '0;
        // A second expiry while one is still pending marks a missed deadline.
        r_d.pend   = r_q.pend | tick;
        r_d.missed = r_q.missed | (tick & r_q.pend);

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.pend) begin
                    r_d.st      = ST_REQ;
                    r_d.goal_sr = 1'b0;
                end else if (sr_req) begin
                    r_d.st      = ST_REQ;
                    r_d.goal_sr = 1'b1;
                end
            end
            ST_REQ: begin
                if (arb_gnt) begin
                    if (!banks_idle) begin
                        r_d.st = ST_PRE;
                    end else if (r_q.goal_sr) begin
                        r_d.st = ST_SR_ENTER;
                    end else begin
                        r_d.st = ST_REF;
                    end
                    if (r_q.goal_sr) begin
                        if (banks_idle) begin
                            r_d.pend   = 1'b0;
                            r_d.missed = 1'b0;
                        end
                    end else begin
                        r_d.pend   = tick;
                        r_d.missed = 1'b0;
                        r_d.extra  = r_q.missed;
                    end
                end
            end
            ST_PRE: begin
                dly_load = 1'b1;
                dly_val  = LD_TRP;
                r_d.st   = ST_TRP;
            end
            ST_TRP: begin
                if (dly_zero) begin
                    if (r_q.goal_sr) begin
                        r_d.st     = ST_SR_ENTER;
                        r_d.pend   = 1'b0;
                        r_d.missed = 1'b0;
                    end else begin
                        r_d.st = ST_REF;
                    end
                end
            end
            ST_REF: begin
                dly_load = 1'b1;
                dly_val  = LD_RFC;
                r_d.st   = ST_RFC;
            end
            ST_RFC: begin
                if (dly_zero) begin
                    if (r_q.extra) begin
                        r_d.st    = ST_REF;
                        r_d.extra = 1'b0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_SR_ENTER: begin
                r_d.st = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (!sr_req) begin
                    dly_load = 1'b1;
                    dly_val  = LD_EXIT;
                    r_d.st   = ST_SR_EXIT;
                end
            end
            ST_SR_EXIT: begin
                if (dly_zero) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st      <= ST_IDLE;
            r_q.goal_sr <= 1'b0;
            r_q.pend    <= 1'b0;
            r_q.missed  <= 1'b0;
            r_q.extra   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // Moore outputs decoded from the registered state.
    always_comb begin
        arb_req = (r_q.st != ST_IDLE);
        sr_ack  = (r_q.st == ST_SR_ENTER) || (r_q.st == ST_SR_HOLD) ||
                  (r_q.st == ST_SR_EXIT);
        cke     = !((r_q.st == ST_SR_ENTER) || (r_q.st == ST_SR_HOLD));
        hold    = sr_ack;
        unique case (r_q.st)
            ST_PRE:      cmd = CMD_PREA;
            ST_REF:      cmd = CMD_AREF;
            ST_SR_ENTER: cmd = CMD_SREF;
            default:     cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
`timescale 1ns/1ps
module sdram_refresh_seq #(
    parameter int unsigned CLK_PS        = 8000,
    parameter int unsigned TRFC_PS       = 80000,
    parameter int unsigned TRP_PS        = 24000,
    parameter int unsigned REF_WINDOW_NS = 64000000,
    parameter int unsigned REF_COUNT     = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arb_gnt,
    input  logic       banks_idle,
    input  logic       sr_req,
    output logic       arb_req,
    output logic       cke,
    output logic [1:0] cmd,
    output logic       sr_ack
);
    // Minimum spacings round up; the average interval rounds down.
    localparam int unsigned TRP_RAW = (TRP_PS + CLK_PS - 1) / CLK_PS;
    localparam int unsigned RFC_RAW = (TRFC_PS + CLK_PS - 1) / CLK_PS;
    localparam int unsigned TRP_CYC = (TRP_RAW < 2) ? 2 : TRP_RAW;
    localparam int unsigned RFC_CYC = (RFC_RAW < 2) ? 2 : RFC_RAW;
    localparam logic [63:0] REFI_RAW =
        (64'(REF_WINDOW_NS) * 64'd1000) / (64'(REF_COUNT) * 64'(CLK_PS));
    localparam int unsigned REFI_CYC = (REFI_RAW < 64'd4) ? 4 : 32'(REFI_RAW);
    localparam int unsigned DLY_MAX  = (TRP_CYC > RFC_CYC) ? TRP_CYC : RFC_CYC;
    localparam int unsigned DLY_W    = $clog2(DLY_MAX + 1);

    logic             tick;
    logic             hold;
    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_zero;

    rf_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .tick (tick)
    );

    rf_delay_cnt #(.W(DLY_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    rf_seq_fsm #(
        .DLY_W   (DLY_W),
        .TRP_CYC (TRP_CYC),
        .RFC_CYC (RFC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .dly_zero   (dly_zero),
        .arb_gnt    (arb_gnt),
        .banks_idle (banks_idle),
        .sr_req     (sr_req),
        .dly_load   (dly_load),
        .dly_val    (dly_val),
        .hold       (hold),
        .arb_req    (arb_req),
        .cke        (cke),
        .cmd        (cmd),
        .sr_ack     (sr_ack)
    );
endmodule

// File: rtl/rf_seq_checker.sv
`timescale 1ns/1ps
module rf_seq_checker
    import sdram_rf_pkg::*;
#(
    parameter int unsigned TRP_CYC = 3,
    parameter int unsigned RFC_CYC = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       arb_req,
    input logic       cke,
    input logic [1:0] cmd,
    input logic       sr_ack
);
    localparam int unsigned GW = $clog2(RFC_CYC + TRP_CYC + 2);
    localparam logic [GW-1:0] RFC_G = GW'(RFC_CYC);
    localparam logic [GW-1:0] TRP_G = GW'(TRP_CYC);

    // Cycles since the last refresh or CKE rise, and since the last precharge.
    logic [GW-1:0] gap_rfc_q, gap_rp_q;
    logic          cke_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_rfc_q <= RFC_G;
            gap_rp_q  <= TRP_G;
            cke_q     <= 1'b1;
        end else begin
            cke_q <= cke;
            if (cmd == CMD_AREF || (cke && !cke_q)) begin
                gap_rfc_q <= GW'(1);
            end else if (gap_rfc_q < RFC_G) begin
                gap_rfc_q <= gap_rfc_q + 1'b1;
            end
            if (cmd == CMD_PREA) begin
                gap_rp_q <= GW'(1);
            end else if (gap_rp_q < TRP_G) begin
                gap_rp_q <= gap_rp_q + 1'b1;
            end
        end
    end

    p_cmd_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> arb_req);

    p_req_first_cycle_nop_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_req) |-> (cmd == CMD_NOP));

    p_trp_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_AREF || cmd == CMD_SREF) |-> (gap_rp_q >= TRP_G));

    p_rfc_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> (gap_rfc_q >= RFC_G));

    p_cke_low_only_in_sr_r8: assert property (@(posedge clk) disable iff (rst)
        !cke |-> sr_ack);

    p_sref_with_cke_low_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SREF) |-> (!cke && sr_ack));

    p_ack_fall_after_rfc_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_ack) |-> (cke && !arb_req && gap_rfc_q >= RFC_G));
endmodule

bind sdram_refresh_seq rf_seq_checker #(
    .TRP_CYC (TRP_CYC),
    .RFC_CYC (RFC_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .arb_req (arb_req),
    .cke     (cke),
    .cmd     (cmd),
    .sr_ack  (sr_ack)
);

// File: tb/sim_sdram_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_refresh_seq;
    localparam int CLK_PS = 8000;
    localparam int TRFC_PS = 76000;
    localparam int TRP_PS = 20000;
    localparam int WIN_NS = 4000;
    localparam int NREF = 8;
    localparam int REFI = (WIN_NS * 1000) / (NREF * CLK_PS);
    localparam int TRP_N = (TRP_PS + CLK_PS - 1) / CLK_PS;
    localparam int RFC_N = (TRFC_PS + CLK_PS - 1) / CLK_PS;
    // Expected-item encoding: [1:0] command, [2] cke, [3] sr_ack.
    localparam int I_NOP = 4, I_PREA = 5, I_AREF = 6, I_SREF = 11, I_XNOP = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arb_gnt = 1'b0;
    logic banks_idle = 1'b1;
    logic sr_req = 1'b0;
    logic arb_req, cke, sr_ack;
    logic [1:0] cmd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int gnt_delay = 0;
    int req_age = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    sdram_refresh_seq #(
        .CLK_PS(CLK_PS), .TRFC_PS(TRFC_PS), .TRP_PS(TRP_PS),
        .REF_WINDOW_NS(WIN_NS), .REF_COUNT(NREF)
    ) u0 (
        .clk(clk), .rst(rst), .arb_gnt(arb_gnt), .banks_idle(banks_idle),
        .sr_req(sr_req), .arb_req(arb_req), .cke(cke), .cmd(cmd), .sr_ack(sr_ack)
    );

    // Behavioural reference: a per-cycle queue of expected outputs.
    int m_mode = 0;   // 0 idle, 1 requesting, 2 playing queue, 3 self refresh
    int m_age = 0;
    bit m_pend = 0, m_missed = 0, m_goal_sr = 0;
    int mq[$];
    logic [1:0] e_cmd = 2'd0;
    logic e_cke = 1'b1, e_req = 1'b0, e_ack = 1'b0;

    always @(posedge clk) begin : model
        bit tick, np, nm;
        int it;
        if (rst) begin
            m_mode = 0; m_age = 0; m_pend = 0; m_missed = 0; mq.delete();
        end else begin
            tick = !e_ack && (m_age == REFI - 1);
            if (e_ack || tick) m_age = 0; else m_age++;
            np = m_pend | tick;
            nm = m_missed | (tick & m_pend);
            case (m_mode)
                0: begin
                    if (m_pend) begin m_mode = 1; m_goal_sr = 0; end
                    else if (sr_req) begin m_mode = 1; m_goal_sr = 1; end
                end
                1: begin
                    if (arb_gnt) begin
                        if (!banks_idle) begin
                            mq.push_back(I_PREA);
                            repeat (TRP_N - 1) mq.push_back(I_NOP);
                        end
                        if (m_goal_sr) begin
                            mq.push_back(I_SREF);
                        end else begin
                            repeat (m_missed ? 2 : 1) begin
                                mq.push_back(I_AREF);
                                repeat (RFC_N - 1) mq.push_back(I_NOP);
                            end
                            np = tick; nm = 0;
                        end
                        m_mode = 2;
                    end
                end
                2: begin
                    it = mq.pop_front();
                    if (it == I_SREF) m_mode = 3;
                    else if (mq.size() == 0) m_mode = 0;
                end
                default: begin
                    if (!sr_req) begin
                        repeat (RFC_N) mq.push_back(I_XNOP);
                        m_mode = 2;
                    end
                end
            endcase
            if (m_mode == 2 && mq[0] == I_SREF) begin np = 0; nm = 0; end
            m_pend = np;
            m_missed = nm;
        end
        e_req = (m_mode != 0);
        if (m_mode == 2) begin
            it = mq[0];
            e_cmd = it[1:0]; e_cke = it[2]; e_ack = it[3];
        end else if (m_mode == 3) begin
            e_cmd = 2'd0; e_cke = 1'b0; e_ack = 1'b1;
        end else begin
            e_cmd = 2'd0; e_cke = 1'b1; e_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: compare against the reference at the falling edge, then drive the grant.
    task automatic step();
        @(negedge clk);
        cyc++;
        checks++;
        if (cmd !== e_cmd || cke !== e_cke || arb_req !== e_req || sr_ack !== e_ack) begin
            errors++;
            $display("FAIL %s cycle %0d cmd/cke/req/ack: actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     cur_req, cyc, cmd, cke, arb_req, sr_ack, e_cmd, e_cke, e_req, e_ack);
        end
        if (arb_req) req_age++; else req_age = 0;
        arb_gnt = arb_req && (req_age > gnt_delay);
    endtask

    task automatic wait_req_low();
        for (int k = 0; k < 600 && arb_req; k++) step();
    endtask

    initial begin : watchdog
        repeat (30000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 30000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int first, t0, t1, nref, tc;
        // R1: reset state
        repeat (3) step();
        chk(cmd == 2'd0, "R1", "cmd in reset", cmd, 0);
        chk(cke == 1'b1, "R1", "cke in reset", cke, 1);
        chk(arb_req == 1'b0, "R1", "arb_req in reset", arb_req, 0);
        chk(sr_ack == 1'b0, "R1", "sr_ack in reset", sr_ack, 0);
        rst = 1'b0;

        // R2, R3, R5: plain refresh, immediate grant, idle banks
        cur_req = "R2";
        gnt_delay = 0; banks_idle = 1'b1;
        first = -1;
        for (int k = 1; k <= 300 && first < 0; k++) begin
            step();
            if (arb_req) first = k;
        end
        chk(first == REFI + 1, "R2", "cycles to first request", first, REFI + 1);
        cur_req = "R5";
        t0 = 1;
        for (int k = 0; k < 100 && arb_req; k++) begin
            step();
            if (arb_req) t0++;
        end
        chk(t0 == RFC_N + 1, "R5", "request length of one refresh", t0, RFC_N + 1);

        // R4, R7: open banks and a late grant force precharge then tRP
        cur_req = "R4";
        banks_idle = 1'b0; gnt_delay = 4;
        t0 = -1; t1 = -1;
        for (int k = 0; k < 300 && t1 < 0; k++) begin
            step();
            if (cmd == 2'd1) t0 = cyc;
            if (cmd == 2'd2) t1 = cyc;
        end
        chk(t0 > 0 && t1 - t0 == TRP_N, "R4", "precharge to refresh spacing", t1 - t0, TRP_N);
        wait_req_low();

        // R6, R7: grant withheld past a second expiry
        cur_req = "R6";
        banks_idle = 1'b1; gnt_delay = 100;
        for (int k = 0; k < 300 && !arb_req; k++) step();
        nref = 0; t0 = -1; t1 = -1;
        for (int k = 0; k < 400 && arb_req; k++) begin
            step();
            if (cmd == 2'd2) begin
                nref++;
                if (t0 < 0) t0 = cyc; else t1 = cyc;
            end
        end
        chk(nref == 2, "R6", "refreshes after missed deadline", nref, 2);
        chk(t1 - t0 == RFC_N, "R7", "back-to-back refresh spacing", t1 - t0, RFC_N);

        // R8, R9, R11: self refresh with open banks
        cur_req = "R8";
        gnt_delay = 2; banks_idle = 1'b0; sr_req = 1'b1;
        for (int k = 0; k < 400 && !sr_ack; k++) step();
        chk(cke == 1'b0, "R8", "cke on self-refresh entry", cke, 0);
        chk(cmd == 2'd3, "R8", "command on self-refresh entry", cmd, 3);
        cur_req = "R11";
        nref = 0;
        for (int k = 0; k < 150; k++) begin
            step();
            if (cmd == 2'd2) nref++;
        end
        chk(nref == 0, "R11", "refreshes during self refresh", nref, 0);
        chk(cke == 1'b0, "R8", "cke held low", cke, 0);
        cur_req = "R9";
        sr_req = 1'b0; gnt_delay = 0; banks_idle = 1'b1;
        t0 = -1; t1 = -1;
        for (int k = 0; k < 100 && t1 < 0; k++) begin
            step();
            if (cke && t0 < 0) t0 = cyc;
            if (!sr_ack && t1 < 0) t1 = cyc;
        end
        chk(t1 - t0 == RFC_N, "R9", "cke rise to acknowledge fall", t1 - t0, RFC_N);
        chk(arb_req == 1'b0, "R9", "arb_req after exit", arb_req, 0);
        cur_req = "R11";
        first = -1;
        for (int k = 1; k <= 300 && first < 0; k++) begin
            step();
            if (arb_req) first = k;
        end
        chk(first == REFI + 1, "R11", "cycles to request after exit", first, REFI + 1);
        wait_req_low();

        // R10: refresh pending together with a self-refresh request
        cur_req = "R10";
        for (int k = 0; k < 200 && !(m_age == REFI - 1 && !arb_req); k++) step();
        step();
        sr_req = 1'b1;
        tc = -1;
        for (int k = 0; k < 100 && tc < 0; k++) begin
            step();
            if (cmd != 2'd0) tc = cmd;
        end
        chk(tc == 2, "R10", "first command with both pending", tc, 2);
        for (int k = 0; k < 100 && !sr_ack; k++) step();
        chk(sr_ack == 1'b1, "R10", "self refresh after the refresh", sr_ack, 1);
        repeat (5) step();
        sr_req = 1'b0;
        for (int k = 0; k < 100 && sr_ack; k++) step();
        repeat (5) step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule